// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one channel of a DMA engine. It copies a run of equal-width elements between a fixed device register address and a range of memory. Each element is first read from its source and then written to its destination, over a simple request/acknowledge memory port. A transfer is described by four 32-bit words: a device address, a memory address, a size word and a next word. The size word holds an element count and a width code. The next word holds a chaining address and two control bits.

The channel starts on a one-cycle `start_i` pulse. In single mode it runs the descriptor presented on the `os_*` inputs. In chained mode it fetches descriptors from memory, beginning at `sg_ptr_i`. In either mode, a descriptor whose follow bit is set makes the channel fetch the next descriptor from the address held in that descriptor's next word.

The channel reports its activity on a two-bit state output. It raises a one-cycle completion pulse for descriptors that ask for one, and a one-cycle error pulse for descriptors it rejects. Driving the mode input to zero stops the channel at once.

Top module: `dchain_dma`

## Requirements
- R1: After reset, `state_o` is 0, and `mem_req_o`, `done_o` and `err_o` are all low.
- R2: With `mode_i` = 2, a `start_i` pulse runs the descriptor on the `os_*` inputs.
  - The element count is `size[11:0]` and the width code is `size[13:12]`: 0 means 4 bytes, 2 means 2 bytes, 3 means 1 byte.
  - The device address stays fixed for the whole descriptor.
  - The memory address steps by the element width after every element.
- R3: When `dir_i` is 1, each element is read from the memory address and written to the device address. When `dir_i` is 0, it is read from the device address and written to the memory address. The written data equals the data just read.
- R4: With `mode_i` = 1, a `start_i` pulse fetches a descriptor from `sg_ptr_i` with its low two bits cleared. The four words are read at offsets 0, 4, 8 and 12, in the order device address, memory address, size, next.
- R5: In the next word, bit 1 set means follow the chain and bit 0 set means raise a completion pulse. When bit 1 is set, the channel next fetches a descriptor from the next word with its low two bits cleared. When bit 1 is clear, the channel returns to idle.
- R6: `done_o` pulses for exactly one cycle, in the cycle after the write of a descriptor's last element is acknowledged. It pulses only when bit 0 of that descriptor's next word is set.
- R7: A descriptor is rejected if its width code is 1, its count is 0, or its count exceeds the limit for its width. The limit is 0x3FF for 1-byte and 2-byte widths and 0x7FF for 4-byte width. A rejected descriptor makes no data access, raises `err_o` for one cycle, and returns the channel to idle in that same cycle.
- R8: Setting `mode_i` to 0 while the channel is busy returns it to idle on the next clock. No further request and no pulse follows.
- R9: While `mem_req_o` is high and `mem_ack_i` is low, the request, address and write enable stay unchanged. `mem_size_o` gives log2 of the access size in bytes.
- R10: `state_o` reports 0 for idle, 1 for descriptor fetch, 2 for the one-cycle descriptor check, and 3 for data access. No request is made while the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 off/abort, 1 chained, 2 single |
| dir_i | input | 1 | 1 memory-to-device, 0 device-to-memory |
| start_i | input | 1 | Start pulse, honoured while idle |
| os_dev_i | input | 32 | Single-mode device address |
| os_mem_i | input | 32 | Single-mode memory address |
| os_size_i | input | 14 | Single-mode size word (count and width code) |
| os_next_i | input | 32 | Single-mode next word |
| sg_ptr_i | input | 32 | First descriptor address in chained mode |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_size_o | output | 2 | log2 of access bytes |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access accepted (read data valid) |
| mem_rdata_i | input | 32 | Read data |
| state_o | output | 2 | Activity state |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Rejected-descriptor pulse |

## Verification
The bound checker watches the handshake on every cycle: the request must be held stable until it is acknowledged, and no request may appear while the channel is idle. It also checks on every cycle that an abort reaches idle within one clock, that an error pulse coincides with idle, and that the completion pulse lasts a single cycle. Only the bench scenarios can show the data path itself. These scenarios cover addresses stepping by width, the direction swap, descriptor fetch order, chaining to a second descriptor, count limits at both widths, and which descriptors produce a completion pulse. A scoreboard compares every accepted write against the address and data predicted from the memory image.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_CHECK = 3'd2,
        ST_READ  = 3'd3,
        ST_WRITE = 3'd4
    } dma_st_e;

    localparam logic [1:0] MODE_OFF    = 2'd0;
    localparam logic [1:0] MODE_CHAIN  = 2'd1;
    localparam logic [1:0] MODE_SINGLE = 2'd2;

    localparam logic [1:0] ACT_IDLE = 2'd0;
    localparam logic [1:0] ACT_DESC = 2'd1;
    localparam logic [1:0] ACT_WAIT = 2'd2;
    localparam logic [1:0] ACT_XFER = 2'd3;
endpackage

// File: rtl/dmac_desc_check.sv
module dmac_desc_check #(
    parameter int CNT_W      = 12,
    parameter int LIM_NARROW = 'h3FF,
    parameter int LIM_WIDE   = 'h7FF
) (
    input  logic [CNT_W+1:0] size_i,
    output logic             ok_o,
    output logic [2:0]       step_o,
    output logic [1:0]       lg_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LIM_N = CNT_W'(LIM_NARROW);
    localparam logic [CNT_W-1:0] LIM_W = CNT_W'(LIM_WIDE);

    logic [1:0]       wcode;
    logic [CNT_W-1:0] lim;
    logic             bad_code;

    assign wcode = size_i[CNT_W+1:CNT_W];
    assign cnt_o = size_i[CNT_W-1:0];

    always_comb begin
        bad_code = 1'b0;
        step_o   = 3'd4;
        lg_o     = 2'd2;
        lim      = LIM_W;
        case (wcode)
            2'd0: begin step_o = 3'd4; lg_o = 2'd2; lim = LIM_W; end
            2'd2: begin step_o = 3'd2; lg_o = 2'd1; lim = LIM_N; end
            2'd3: begin step_o = 3'd1; lg_o = 2'd0; lim = LIM_N; end
            default: bad_code = 1'b1;
        endcase
    end

    assign ok_o = !bad_code && (cnt_o != '0) && (cnt_o <= lim);
endmodule

// File: rtl/dmac_req_mux.sv
module dmac_req_mux
    import dmac_pkg::*;
(
    input  dma_st_e     st_i,
    input  logic        dir_i,
    input  logic [1:0]  widx_i,
    input  logic [31:0] ptr_i,
    input  logic [31:0] dev_i,
    input  logic [31:0] mem_i,
    input  logic [31:0] data_i,
    input  logic [1:0]  lg_i,
    output logic        req_o,
    output logic        we_o,
    output logic [31:0] addr_o,
    output logic [1:0]  size_o,
    output logic [31:0] wdata_o
);
    always_comb begin
        req_o  = 1'b0;
        we_o   = 1'b0;
        addr_o = '0;
        size_o = 2'd2;
        case (st_i)
            ST_FETCH: begin
                req_o  = 1'b1;
                addr_o = ptr_i + {28'd0, widx_i, 2'b00};
            end
            ST_READ: begin
                req_o  = 1'b1;
                addr_o = dir_i ? mem_i : dev_i;
                size_o = lg_i;
            end
            ST_WRITE: begin
                req_o  = 1'b1;
                we_o   = 1'b1;
                addr_o = dir_i ? dev_i : mem_i;
                size_o = lg_i;
            end
            default: ;
        endcase
    end

    assign wdata_o = data_i;
endmodule

// File: rtl/dchain_dma.sv
module dchain_dma
    import dmac_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int LIM_NARROW = 'h3FF,
    parameter int LIM_WIDE   = 'h7FF,
    localparam int SZ_W      = CNT_W + 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       mode_i,
    input  logic             dir_i,
    input  logic             start_i,
    input  logic [31:0]      os_dev_i,
    input  logic [31:0]      os_mem_i,
    input  logic [SZ_W-1:0]  os_size_i,
    input  logic [31:0]      os_next_i,
    input  logic [31:0]      sg_ptr_i,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [31:0]      mem_addr_o,
    output logic [1:0]       mem_size_o,
    output logic [31:0]      mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [31:0]      mem_rdata_i,
    output logic [1:0]       state_o,
    output logic             done_o,
    output logic             err_o
);
    typedef struct packed {
        dma_st_e          st;
        logic [1:0]       widx;
        logic [31:0]      ptr;
        logic [31:0]      dev;
        logic [31:0]      mem;
        logic [SZ_W-1:0]  size;
        logic [31:0]      nxt;
        logic [CNT_W-1:0] left;
        logic [31:0]      data;
        logic             done;
        logic             err;
    } regs_t;

    regs_t q, d;

    logic             chk_ok;
    logic [2:0]       step;
    logic [1:0]       lg;
    logic [CNT_W-1:0] cnt;

    dmac_desc_check #(
        .CNT_W(CNT_W), .LIM_NARROW(LIM_NARROW), .LIM_WIDE(LIM_WIDE)
    ) check_i (
        .size_i(q.size), .ok_o(chk_ok), .step_o(step), .lg_o(lg), .cnt_o(cnt)
    );

    dmac_req_mux req_i (
        .st_i(q.st), .dir_i(dir_i), .widx_i(q.widx), .ptr_i(q.ptr),
        .dev_i(q.dev), .mem_i(q.mem), .data_i(q.data), .lg_i(lg),
        .req_o(mem_req_o), .we_o(mem_we_o), .addr_o(mem_addr_o),
        .size_o(mem_size_o), .wdata_o(mem_wdata_o)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        if (mode_i == MODE_OFF) begin
            d.st = ST_IDLE;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (start_i && mode_i == MODE_SINGLE) begin
                        d.dev  = os_dev_i;
                        d.mem  = os_mem_i;
                        d.size = os_size_i;
                        d.nxt  = os_next_i;
                        d.st   = ST_CHECK;
                    end else if (start_i && mode_i == MODE_CHAIN) begin
                        d.ptr  = sg_ptr_i & ~32'h3;
                        d.widx = 2'd0;
                        d.st   = ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack_i) begin
                        case (q.widx)
                            2'd0: d.dev  = mem_rdata_i;
                            2'd1: d.mem  = mem_rdata_i;
                            2'd2: d.size = mem_rdata_i[SZ_W-1:0];
                            default: d.nxt = mem_rdata_i;
                        endcase
                        d.widx = q.widx + 2'd1;
                        if (q.widx == 2'd3) d.st = ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (chk_ok) begin
                        d.left = cnt;
                        d.st   = ST_READ;
                    end else begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (mem_ack_i) begin
                        d.data = mem_rdata_i;
                        d.st   = ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack_i) begin
                        d.mem  = q.mem + 32'(step);
                        d.left = q.left - 1'b1;
                        if (q.left == CNT_W'(1)) begin
                            d.done = q.nxt[0];
                            if (q.nxt[1]) begin
                                d.ptr  = q.nxt & ~32'h3;
                                d.widx = 2'd0;
                                d.st   = ST_FETCH;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            d.st = ST_READ;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        case (q.st)
            ST_FETCH:          state_o = ACT_DESC;
            ST_CHECK:          state_o = ACT_WAIT;
            ST_READ, ST_WRITE: state_o = ACT_XFER;
            default:           state_o = ACT_IDLE;
        endcase
    end

    assign done_o = q.done;
    assign err_o  = q.err;
endmodule

// File: rtl/dchain_dma_chk.sv
module dchain_dma_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [1:0]  mode_i,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_ack_i,
    input logic [1:0]  state_o,
    input logic        done_o,
    input logic        err_o
);
    p_abort_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd0 && state_o != 2'd0) |=> (state_o == 2'd0 && !mem_req_o));

    p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o && !mem_ack_i && mode_i != 2'd0)
            |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    p_err_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (state_o == 2'd0 && !done_o));

    p_idle_noreq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'd0) |-> !mem_req_o);

    p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
endmodule

bind dchain_dma dchain_dma_chk chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
    .state_o(state_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/dchain_dma_tb_top.sv
`timescale 1ns/1ps
module dchain_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        dir = 1'b0;
    logic        start = 1'b0;
    logic [31:0] os_dev = '0, os_mem = '0, os_next = '0, sg_ptr = '0;
    logic [13:0] os_size = '0;
    logic        req, we, done, err;
    logic [31:0] addr, wdata;
    logic [1:0]  msize, state;
    logic        ack = 1'b0;
    logic [31:0] rdata = '0;

    always #2.5 clk = ~clk;

    dchain_dma dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dir_i(dir), .start_i(start),
        .os_dev_i(os_dev), .os_mem_i(os_mem), .os_size_i(os_size),
        .os_next_i(os_next), .sg_ptr_i(sg_ptr),
        .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_size_o(msize),
        .mem_wdata_o(wdata), .mem_ack_i(ack), .mem_rdata_i(rdata),
        .state_o(state), .done_o(done), .err_o(err)
    );

    typedef struct { logic [31:0] a; logic [31:0] d; string tag; } item_t;
    item_t exp_q[$];

    logic [31:0] mem_arr [4096];
    int n_chk = 0, n_fail = 0, wr_cnt = 0, done_cnt = 0, err_cnt = 0;
    bit sb_en = 1'b1;
    bit finished = 1'b0;
    logic [3:0] seen = '0;

    function automatic logic [31:0] init_val(int idx);
        return {16'hBEEF ^ 16'(idx * 7), 16'(idx)};
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic reinit();
        for (int i = 0; i < 4096; i++) mem_arr[i] = init_val(i);
    endtask

    // driver side: expected writes
    task automatic push_elems(bit d2, logic [31:0] dv, logic [31:0] mm,
                              logic [1:0] wc, int cnt, string tag);
        int st;
        st = (wc == 2'd0) ? 4 : (wc == 2'd2) ? 2 : 1;
        for (int i = 0; i < cnt; i++) begin
            item_t it;
            logic [31:0] ma, src;
            ma = mm + 32'(i * st);
            src = d2 ? ma : dv;
            it.a = d2 ? dv : ma;
            it.d = init_val(int'(src[13:2]));
            it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    // memory model and monitor
    always @(negedge clk) begin
        seen[state] = 1'b1;
        if (done) done_cnt++;
        if (err) err_cnt++;
        if (ack) ack = 1'b0;
        else if (req) begin
            ack = 1'b1;
            if (we) begin
                mem_arr[addr[13:2]] = wdata;
                wr_cnt++;
                if (sb_en) begin
                    if (exp_q.size() == 0) chk(0, "R3", "unexpected write addr", addr, 32'h0);
                    else begin
                        item_t it;
                        it = exp_q.pop_front();
                        chk(addr == it.a, it.tag, "write address", addr, it.a);
                        chk(wdata == it.d, it.tag, "write data", wdata, it.d);
                    end
                end
            end else rdata = mem_arr[addr[13:2]];
        end
    end

    task automatic run(logic [1:0] md, bit d2, logic [31:0] dv, logic [31:0] mm,
                       logic [13:0] sz, logic [31:0] nx, logic [31:0] sp);
        int guard;
        @(negedge clk);
        mode = md; dir = d2; os_dev = dv; os_mem = mm; os_size = sz;
        os_next = nx; sg_ptr = sp; start = 1'b1; seen = '0;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (state != 2'd0 && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        int d0, e0, w0;
        reinit();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(state == 2'd0, "R1", "state after reset", 32'(state), 0);
        chk(!req && !done && !err, "R1", "req/done/err after reset", {29'd0, req, done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R6 R10: single, mem-to-dev, 4-byte x3, interrupt
        d0 = done_cnt;
        push_elems(1, 32'h3F00, 32'h100, 2'd0, 3, "R2");
        run(2'd2, 1, 32'h3F00, 32'h100, {2'd0, 12'd3}, 32'h1, 0);
        chk(exp_q.size() == 0, "R2", "pending writes", exp_q.size(), 0);
        chk(done_cnt == d0 + 1, "R6", "done pulses with bit0", done_cnt - d0, 1);
        chk(seen[2] && seen[3], "R10", "check and access states seen", 32'(seen), 32'hC);

        // R3 R6: dev-to-mem, 2-byte x4, silent
        reinit(); d0 = done_cnt;
        push_elems(0, 32'h3F04, 32'h201, 2'd2, 4, "R3");
        run(2'd2, 0, 32'h3F04, 32'h201, {2'd2, 12'd4}, 32'h0, 0);
        chk(exp_q.size() == 0, "R3", "pending writes", exp_q.size(), 0);
        chk(done_cnt == d0, "R6", "no done when bit0 clear", done_cnt - d0, 0);

        // R2: 1-byte step
        reinit();
        push_elems(1, 32'h3F10, 32'h300, 2'd3, 5, "R2");
        run(2'd2, 1, 32'h3F10, 32'h300, {2'd3, 12'd5}, 32'h0, 0);
        chk(exp_q.size() == 0, "R2", "1-byte pending writes", exp_q.size(), 0);

        // R4 R5: chained two descriptors
        reinit(); d0 = done_cnt;
        mem_arr[32'h800 >> 2]       = 32'h3F08;
        mem_arr[(32'h800 >> 2) + 1] = 32'h400;
        mem_arr[(32'h800 >> 2) + 2] = {18'd0, 2'd0, 12'd2};
        mem_arr[(32'h800 >> 2) + 3] = 32'h810 | 32'h2;
        mem_arr[32'h810 >> 2]       = 32'h3F08;
        mem_arr[(32'h810 >> 2) + 1] = 32'h500;
        mem_arr[(32'h810 >> 2) + 2] = {18'd0, 2'd2, 12'd3};
        mem_arr[(32'h810 >> 2) + 3] = 32'h1;
        push_elems(1, 32'h3F08, 32'h400, 2'd0, 2, "R4");
        push_elems(1, 32'h3F08, 32'h500, 2'd2, 3, "R5");
        run(2'd1, 1, 0, 0, 0, 0, 32'h803);
        chk(exp_q.size() == 0, "R5", "chain pending writes", exp_q.size(), 0);
        chk(seen[1], "R4", "fetch state seen", 32'(seen), 32'h2);
        chk(done_cnt == d0 + 1, "R5", "done only on final descriptor", done_cnt - d0, 1);

        // R7: rejected descriptors
        reinit(); e0 = err_cnt; w0 = wr_cnt;
        run(2'd2, 1, 32'h3F00, 32'h0, {2'd1, 12'd4}, 32'h1, 0);
        chk(err_cnt == e0 + 1, "R7", "width code 1 error", err_cnt - e0, 1);
        run(2'd2, 1, 32'h3F00, 32'h0, {2'd3, 12'h400}, 32'h1, 0);
        chk(err_cnt == e0 + 2, "R7", "1-byte over limit error", err_cnt - e0, 2);
        run(2'd2, 1, 32'h3F00, 32'h0, {2'd2, 12'h400}, 32'h1, 0);
        chk(err_cnt == e0 + 3, "R7", "2-byte over limit error", err_cnt - e0, 3);
        run(2'd2, 1, 32'h3F00, 32'h0, {2'd0, 12'h0}, 32'h1, 0);
        chk(err_cnt == e0 + 4, "R7", "zero count error", err_cnt - e0, 4);
        run(2'd2, 1, 32'h3F00, 32'h0, {2'd0, 12'h800}, 32'h1, 0);
        chk(err_cnt == e0 + 5, "R7", "4-byte over limit error", err_cnt - e0, 5);
        chk(wr_cnt == w0, "R7", "no writes on error", wr_cnt - w0, 0);
        chk(state == 2'd0, "R7", "idle after error", 32'(state), 0);

        // R7 boundary: 4-byte at limit accepted
        reinit(); e0 = err_cnt;
        push_elems(1, 32'h3F0C, 32'h0, 2'd0, 'h7FF, "R7");
        run(2'd2, 1, 32'h3F0C, 32'h0, {2'd0, 12'h7FF}, 32'h0, 0);
        chk(exp_q.size() == 0, "R7", "limit count fully moved", exp_q.size(), 0);
        chk(err_cnt == e0, "R7", "no error at limit", err_cnt - e0, 0);

        // R8: abort
        reinit(); sb_en = 1'b0; d0 = done_cnt;
        @(negedge clk);
        mode = 2'd2; dir = 1; os_dev = 32'h3F00; os_mem = 32'h0;
        os_size = {2'd0, 12'd100}; os_next = 32'h1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        mode = 2'd0;
        @(negedge clk);
        chk(state == 2'd0, "R8", "idle after abort", 32'(state), 0);
        chk(!req, "R8", "no request after abort", 32'(req), 0);
        w0 = wr_cnt;
        repeat (10) @(negedge clk);
        chk(wr_cnt == w0, "R8", "no writes after abort", wr_cnt - w0, 0);
        chk(done_cnt == d0, "R8", "no done after abort", done_cnt - d0, 0);
        sb_en = 1'b1;

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule